// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment at which an external capture pin changes level. The pin is brought into the clock domain through a synchronizer. It can optionally pass through a digital glitch filter, and then reaches an edge detector whose polarity is programmable. On a qualifying edge, the block copies the value of a free-running counter into a capture register. The counter itself is supplied from outside as an input. Each capture also sets a capture flag, which can raise an interrupt request.

A small register port sets the controls, reads and writes the capture register, and clears the flag. A mode input from the counter logic tells the block when the capture register is serving as the counter's TOP value. While that mode is active, the pin has no effect. The register can still be written by software so that it can hold the TOP value.

Top module: `cap_stamp`

## Requirements
- R1: After reset, the control register reads 0 (filter off, falling-edge trigger, interrupt disabled), the capture register reads 0, the flag reads 0 and `irq` is low.
- R2: Edge select bit = 1 captures on a rising pin edge only. Edge select bit = 0 captures on a falling pin edge only. The other edge leaves the capture register and the flag untouched.
- R3: With the filter off, a pin change first sampled at clock edge E0, while `count_in` = N, loads the capture register with N+2. This value is the counter at edge E2 and reflects two synchronizer stages plus one detection stage.
- R4: With the filter on, the filtered level changes only after four consecutive synchronized samples at the new level. A pulse held for fewer than four clock cycles causes no capture.
- R5: With the filter on, every capture happens four cycles later than with the filter off, so the capture register loads N+6.
- R6: Each capture sets the flag. `irq` is high exactly while the flag and the interrupt-enable bit are both 1.
- R7: The flag clears when 1 is written to address 2 bit 0, or when `irq_ack` pulses. If a capture and a clear fall in the same cycle, the flag stays 1.
- R8: While `top_is_cap` is 1, pin edges cause no capture, leave the capture register unchanged and do not set the flag.
- R9: Control bit 2 is reserved. It always reads 0, and writing it has no effect.
- R10: The capture register at address 1 can be written by software, in either mode, and reads back the written value. A capture in the same cycle takes priority over the write.
- R11: Register map: address 0 is control, with bit 0 as filter enable, bit 1 as edge select, bit 2 reserved and bit 3 as interrupt enable. Address 1 is the capture register. Address 2 holds the flag in bit 0. Read data appears on `rd_data` one clock after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous capture pin |
| count_in | input | CW | Free-running counter value |
| top_is_cap | input | 1 | Counter mode uses the capture register as TOP |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | CW | Register write data |
| rd_data | output | CW | Registered read data |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench sweeps pulse widths from 1 to 6 cycles across both filter settings and both polarities, and predicts each timestamp from the counter value at the moment the pin changed. A filter that counted one sample too few or too many would capture the 3-cycle pulse or drop the 4-cycle one. Latency off by a register would give timestamps off by one. A swapped polarity would stamp the wrong end of the pulse. The bench also lands a flag clear on the exact cycle of a capture, where a clear-wins design would lose the event. It drives pulses while in TOP mode, where a leaky gate would overwrite the TOP value.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CAP  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam int BIT_FILT = 0;
  localparam int BIT_RISE = 1;
  localparam int BIT_RSVD = 2;
  localparam int BIT_IE   = 3;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], din};
  end
  assign dout = sh[STAGES-1];
endmodule

// File: rtl/cap_filt.sv
module cap_filt #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int HW = LEN - 1;
  logic [HW-1:0] hist;
  logic all_hi, all_lo;
  assign all_hi = din & (&hist);
  assign all_lo = ~din & ~(|hist);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      dout <= 1'b0;
    end else begin
      hist <= HW'({hist, din});
      if (all_hi)      dout <= 1'b1;
      else if (all_lo) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;
  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/cap_stamp.sv
module cap_stamp
  import cap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_in,
  input  logic [CW-1:0] count_in,
  input  logic          top_is_cap,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] rd_data,
  input  logic          irq_ack,
  output logic          irq
);
  logic sync_lvl, flt_lvl, sel_lvl, rise, fall, cap_evt;
  logic filt_en_q, rise_sel_q, irq_en_q, flag_q;
  logic [CW-1:0] cap_q;
  logic wr_ctrl, wr_cap, wr_flag, clr;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(sync_lvl));

  cap_filt #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din(sync_lvl), .dout(flt_lvl));

  assign sel_lvl = filt_en_q ? flt_lvl : sync_lvl;

  cap_edge u_edge (
    .clk(clk), .rst(rst), .lvl(sel_lvl), .rise(rise), .fall(fall));

  assign cap_evt = ~top_is_cap & (rise_sel_q ? rise : fall);
  assign wr_ctrl = reg_we && reg_addr == ADDR_CTRL;
  assign wr_cap  = reg_we && reg_addr == ADDR_CAP;
  assign wr_flag = reg_we && reg_addr == ADDR_FLAG;
  assign clr     = irq_ack | (wr_flag & reg_wdata[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_en_q  <= 1'b0;
      rise_sel_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      filt_en_q  <= reg_wdata[BIT_FILT];
      rise_sel_q <= reg_wdata[BIT_RISE];
      irq_en_q   <= reg_wdata[BIT_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cap_q <= '0;
    else if (cap_evt) cap_q <= count_in;
    else if (wr_cap)  cap_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (cap_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign irq = flag_q & irq_en_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (reg_addr)
        ADDR_CTRL: begin
          rd_data[BIT_FILT] <= filt_en_q;
          rd_data[BIT_RISE] <= rise_sel_q;
          rd_data[BIT_IE]   <= irq_en_q;
        end
        ADDR_CAP:  rd_data <= cap_q;
        ADDR_FLAG: rd_data[0] <= flag_q;
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cap_stamp_chk.sv
module cap_stamp_chk #(
  parameter int CW       = 16,
  parameter int FILT_LEN = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          top_is_cap,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [CW-1:0] cap_q,
  input logic          cap_evt,
  input logic          irq_ack,
  input logic          flag_q,
  input logic          sync_lvl,
  input logic          flt_lvl,
  input logic [CW-1:0] rd_data,
  input logic          irq,
  input logic          irq_en_q
);
  assert_top_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (top_is_cap && !(reg_we && reg_addr == 2'd1)) |=> $stable(cap_q));

  assert_evt_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag_q);

  assert_set_beats_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && irq_ack) |=> flag_q);

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd0) |-> (rd_data[2] == 1'b0));

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q && irq_en_q));

  generate
    if (FILT_LEN == 4) begin : g_f4
      assert_filt_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_lvl) |-> ($past(sync_lvl, 1) && $past(sync_lvl, 2) &&
                            $past(sync_lvl, 3) && $past(sync_lvl, 4)));
      assert_filt_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(flt_lvl) |-> (!$past(sync_lvl, 1) && !$past(sync_lvl, 2) &&
                            !$past(sync_lvl, 3) && !$past(sync_lvl, 4)));
    end
  endgenerate
endmodule

bind cap_stamp cap_stamp_chk #(.CW(CW), .FILT_LEN(FILT_LEN)) u_chk (
  .clk(clk), .rst(rst), .top_is_cap(top_is_cap), .reg_we(reg_we),
  .reg_addr(reg_addr), .cap_q(cap_q), .cap_evt(cap_evt), .irq_ack(irq_ack),
  .flag_q(flag_q), .sync_lvl(sync_lvl), .flt_lvl(flt_lvl),
  .rd_data(rd_data), .irq(irq), .irq_en_q(irq_en_q));

// File: tb/sim_cap_stamp.sv
module sim_cap_stamp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0;
  logic [15:0] count_in = '0;
  logic        top_is_cap = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_data;
  logic        irq_ack = 1'b0;
  logic        irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) count_in <= count_in + 16'd1;

  cap_stamp u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .count_in(count_in),
    .top_is_cap(top_is_cap), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse(input int w, output int n);
    @(negedge clk); n = int'(count_in); pin_in = 1'b1;
    repeat (w) @(negedge clk);
    pin_in = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int n, exp_cap, lat;
    bit hit;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); chk("R1 ctrl reset", int'(v), 0);
    rd(2'd1, v); chk("R1 cap reset", int'(v), 0);
    rd(2'd2, v); chk("R1 flag reset", int'(v), 0);
    chk("R1 irq reset", int'(irq), 0);
    exp_cap = 0;

    // R2 R3 R4 R5 sweep: filter x polarity x width
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++)
        for (int w = 1; w <= 6; w++) begin
          wr(2'd0, 16'((p << 1) | f));
          pulse(w, n);
          hit = (f == 0) || (w >= 4);
          lat = 2 + 4 * f;
          if (hit) exp_cap = (p == 1) ? (n + lat) & 16'hFFFF : (n + w + lat) & 16'hFFFF;
          rd(2'd1, v);
          chk($sformatf("R2 R3 R4 R5 cap f=%0d p=%0d w=%0d", f, p, w), int'(v), exp_cap);
          rd(2'd2, v);
          chk($sformatf("R4 R6 flag f=%0d p=%0d w=%0d", f, p, w), int'(v), int'(hit));
          wr(2'd2, 16'd1);
        end
    rd(2'd2, v); chk("R7 write-1 clear", int'(v), 0);

    // R9 reserved bit, R11 ctrl layout
    wr(2'd0, 16'h000F);
    rd(2'd0, v); chk("R9 R11 ctrl readback", int'(v), 16'h000B);

    // R6 irq with enable (rising, no filter, ie on)
    wr(2'd0, 16'h000A);
    pulse(2, n);
    chk("R6 irq asserted", int'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 ack clears irq", int'(irq), 0);
    rd(2'd2, v); chk("R7 ack clears flag", int'(v), 0);

    // R7 clear on the capture cycle
    @(negedge clk); n = int'(count_in); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 2'd2; reg_we = 1'b1; reg_wdata = 16'd1;
    @(negedge clk); reg_we = 1'b0;
    rd(2'd2, v); chk("R7 capture beats clear", int'(v), 1);
    rd(2'd1, v); chk("R3 capture during clear", int'(v), (n + 2) & 16'hFFFF);
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd2, 16'd1);

    // R8 R10 TOP mode
    top_is_cap = 1'b1;
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R10 sw write in TOP mode", int'(v), 16'h1234);
    pulse(5, n);
    rd(2'd1, v); chk("R8 cap held in TOP mode", int'(v), 16'h1234);
    rd(2'd2, v); chk("R8 no flag in TOP mode", int'(v), 0);
    chk("R8 no irq in TOP mode", int'(irq), 0);
    top_is_cap = 1'b0;
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); chk("R10 sw write normal mode", int'(v), 16'hBEEF);
    rd(2'd3, v); chk("R11 unmapped reads zero", int'(v), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule